// File: doc/BRIEF.md
# Down-Counting Interrupt Timer Bank

A register-mapped block holding several independent 32-bit countdown timers (four by default) on a shared word-addressed write/read bus. Each timer picks one of four count-enable strobes (slow, medium, CPU-rate, peripheral-rate) as its time base. The strobes are one-cycle tick inputs in the single clock domain, not separate clocks. Software parks a start value in a timer while it is stopped, then sets the run bit. The counter loads that value and steps down once per selected strobe. When it reaches zero it latches a pending flag, stays at zero and raises its interrupt line if the interrupt is enabled.

The counter never restarts by itself. The expected service sequence is: clear the pending flag, stop the timer, write a fresh start value, run it again. While a timer is stopped its live-count register reads zero. A start-value write made while the timer runs is dropped.

Top module: `timer_bank`

## Requirements
- R1: After reset every register of every timer reads zero and all interrupt outputs are low.
- R2: The control word at offset 0x0 holds the run bit at bit 0 and the strobe select at bits [5:4] (0 slow, 1 medium, 2 CPU-rate, 3 peripheral-rate, indexing `tickIn`). All other bits read zero.
- R3: A control write that sets bit 0 while the timer is stopped loads the start value into the counter, and the live count (offset 0x8) reads that value from the next cycle.
- R4: A running timer decrements by one in each cycle where its selected strobe is high and it is not loading. Strobes it has not selected, and cycles with no write and no strobe, leave every readback unchanged.
- R5: On the strobe that takes the count from 1 to 0, the pending flag sets. The count then holds at zero, and later strobes neither reload nor change it.
- R6: While the run bit is clear, the live count reads zero.
- R7: A write to the start value (offset 0x4) while the timer is stopped is stored and resets the count. While the timer runs, such a write is ignored.
- R8: The acknowledge word (offset 0xC) holds the interrupt enable at bit 0 and reads the pending flag at bit 5. Writing 1 to bit 5 clears pending. The interrupt output equals pending AND enable.
- R9: Timer n occupies byte offsets 0x10*n to 0x10*n+0xC, and an access to one timer never alters another.
- R10: With a start value of zero, the first selected strobe after the timer starts sets pending.
- R11: When an expiry and a write of 1 to acknowledge bit 5 fall in the same cycle, pending stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe for the register bus |
| busAddr | input | 6 | Byte address; bits [1:0] ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| tickIn | input | 4 | Count-enable strobes, index = strobe select code |
| irq | output | 4 | Per-timer interrupt, pending AND enable |

## Verification
A corrupted count shows at the live-count readback on the very next read. It also shows as an interrupt that fires one or more strobes early or late, so a wrong step surfaces within a single strobe period. A stuck done or pending flag shows either as `irq` failing to drop one cycle after an acknowledge write, or as a timer that reaches zero without ever flagging. A decode slip between instances shows as a value written to one timer appearing in another timer's readback at the next read.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_SRC = 4;
  localparam int NUM_REG = 4;

  // register select codes within one timer
  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_RELOAD = 2'd1;
  localparam logic [1:0] REG_COUNT  = 2'd2;
  localparam logic [1:0] REG_ACK    = 2'd3;

  // bit positions
  localparam int RUN_BIT = 0;
  localparam int SRC_LO  = 4;
  localparam int IE_BIT  = 0;
  localparam int CLR_BIT = 5;

  typedef struct packed {
    logic wrCtrl;
    logic wrReload;
    logic wrAck;
  } regCmd_t;
endpackage

// File: rtl/timer_bank_ctrl.sv
module timer_bank_ctrl
  import timer_bank_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int ADDR_W     = 6
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] rdWords [NUM_TIMERS][NUM_REG],
  output regCmd_t           cmd [NUM_TIMERS],
  output logic [DATA_W-1:0] busRdata
);
  localparam int IDX_W = ADDR_W - 4;

  logic [1:0]       regSel;
  logic [IDX_W-1:0] idx;

  assign regSel = busAddr[3:2];
  assign idx    = busAddr[ADDR_W-1:4];

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_dec
    logic hit;
    assign hit = busWr && (idx == IDX_W'(i));
    assign cmd[i].wrCtrl   = hit && (regSel == REG_CTRL);
    assign cmd[i].wrReload = hit && (regSel == REG_RELOAD);
    assign cmd[i].wrAck    = hit && (regSel == REG_ACK);
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (idx == IDX_W'(i)) busRdata = rdWords[i][regSel];
    end
  end
endmodule

// File: rtl/timer_bank_datapath.sv
module timer_bank_datapath
  import timer_bank_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regCmd_t            cmd,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] tickIn,
  output logic [DATA_W-1:0]  rdWord [NUM_REG],
  output logic               irq
);
  logic             runOn, intEn, pending, done;
  logic [1:0]       srcSel;
  logic [CNT_W-1:0] startVal, count;
  logic             loadNow, reloadWr, stepNow, expireNow;

  assign loadNow   = cmd.wrCtrl && wdata[RUN_BIT] && !runOn;
  assign reloadWr  = cmd.wrReload && !runOn;
  assign stepNow   = runOn && !loadNow && tickIn[srcSel] && !done;
  assign expireNow = stepNow && (count <= CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runOn    <= 1'b0;
      srcSel   <= '0;
      intEn    <= 1'b0;
      pending  <= 1'b0;
      done     <= 1'b0;
      startVal <= '0;
      count    <= '0;
    end else begin
      if (cmd.wrCtrl) begin
        runOn  <= wdata[RUN_BIT];
        srcSel <= wdata[SRC_LO+1:SRC_LO];
      end
      if (reloadWr) startVal <= wdata[CNT_W-1:0];
      if (cmd.wrAck) intEn <= wdata[IE_BIT];

      if (loadNow)       count <= startVal;
      else if (reloadWr) count <= '0;
      else if (stepNow)  count <= expireNow ? '0 : count - CNT_W'(1);

      if (loadNow)        done <= 1'b0;
      else if (expireNow) done <= 1'b1;

      if (expireNow)                         pending <= 1'b1;
      else if (cmd.wrAck && wdata[CLR_BIT])  pending <= 1'b0;
    end
  end

  always_comb begin
    rdWord[REG_CTRL]                        = '0;
    rdWord[REG_CTRL][RUN_BIT]               = runOn;
    rdWord[REG_CTRL][SRC_LO+1:SRC_LO]       = srcSel;
    rdWord[REG_RELOAD]                      = DATA_W'(startVal);
    rdWord[REG_COUNT]                       = runOn ? DATA_W'(count) : '0;
    rdWord[REG_ACK]                         = '0;
    rdWord[REG_ACK][IE_BIT]                 = intEn;
    rdWord[REG_ACK][CLR_BIT]                = pending;
  end

  assign irq = pending && intEn;
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int CNT_W      = 32,
  localparam int IDX_W     = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W    = IDX_W + 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NUM_SRC-1:0]    tickIn,
  output logic [NUM_TIMERS-1:0] irq
);
  regCmd_t           cmd     [NUM_TIMERS];
  logic [DATA_W-1:0] rdWords [NUM_TIMERS][NUM_REG];

  timer_bank_ctrl #(.NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W)) u_ctrl (
    .busWr    (busWr),
    .busAddr  (busAddr),
    .rdWords  (rdWords),
    .cmd      (cmd),
    .busRdata (busRdata)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    timer_bank_datapath #(.CNT_W(CNT_W)) u_dp (
      .clk    (clk),
      .rstN   (rstN),
      .cmd    (cmd[i]),
      .wdata  (busWdata),
      .tickIn (tickIn),
      .rdWord (rdWords[i]),
      .irq    (irq[i])
    );
  end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
  parameter int NUM_TIMERS = 4,
  parameter int ADDR_W     = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWr,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [31:0]           busWdata,
  input logic [31:0]           busRdata,
  input logic [3:0]            tickIn,
  input logic [NUM_TIMERS-1:0] irq
);
  localparam logic [ADDR_W-1:0] CTRL0 = ADDR_W'(6'h0);
  localparam logic [ADDR_W-1:0] CUR0  = ADDR_W'(6'h8);
  localparam logic [ADDR_W-1:0] ACK0  = ADDR_W'(6'hC);

  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> irq == '0);

  p_ctrl_reserved_r2: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == CTRL0 |-> (busRdata[31:6] == '0 && busRdata[3:1] == '0));

  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busWr && tickIn == '0) |=> (!$stable(busAddr) || $stable(busRdata)));

  p_expiry_needs_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq[0]) |-> ($past(tickIn) != '0 || $past(busWr && busAddr == ACK0 && busWdata[0])));

  p_stopped_reads_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == CTRL0 && !busWdata[0]) |=> (busAddr != CUR0 || busRdata == '0));

  p_ie_off_drops_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ACK0 && !busWdata[0]) |=> !irq[0]);

  p_clear_drops_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ACK0 && busWdata[5] && tickIn == '0) |=> !irq[0]);
endmodule

bind timer_bank timer_bank_chk #(.NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .busRdata(busRdata), .tickIn(tickIn), .irq(irq)
);

// File: tb/sim_timer_bank.sv
module sim_timer_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  tickIn = '0;
  logic [3:0]  irq;

  int errors = 0;
  int checks = 0;

  // bench-side model state
  logic        mRun [NT];
  logic [1:0]  mSrc [NT];
  logic        mIe [NT];
  logic        mPend [NT];
  logic        mDone [NT];
  logic [31:0] mStart [NT];
  logic [31:0] mCount [NT];

  timer_bank u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .tickIn(tickIn), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expWord(input logic [5:0] a);
    int i = int'(a[5:4]);
    case (a[3:2])
      2'd0: return {26'b0, mSrc[i], 3'b0, mRun[i]};
      2'd1: return mStart[i];
      2'd2: return mRun[i] ? mCount[i] : 32'd0;
      default: return {26'b0, mPend[i], 4'b0, mIe[i]};
    endcase
  endfunction

  function automatic logic [3:0] expIrq();
    logic [3:0] v;
    for (int i = 0; i < NT; i++) v[i] = mPend[i] && mIe[i];
    return v;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NT; i++) begin
      mRun[i] = 0; mSrc[i] = 0; mIe[i] = 0; mPend[i] = 0;
      mDone[i] = 0; mStart[i] = 0; mCount[i] = 0;
    end
  endtask

  task automatic modelStep(input logic wr, input logic [5:0] a, input logic [31:0] d,
                           input logic [3:0] t);
    for (int i = 0; i < NT; i++) begin
      logic hit = wr && (int'(a[5:4]) == i);
      logic wc = hit && a[3:2] == 2'd0;
      logic wrl = hit && a[3:2] == 2'd1;
      logic wa = hit && a[3:2] == 2'd3;
      logic load = wc && d[0] && !mRun[i];
      logic rlw = wrl && !mRun[i];
      logic step = mRun[i] && !load && t[mSrc[i]] && !mDone[i];
      logic exp = step && (mCount[i] <= 32'd1);
      logic [31:0] nCount = mCount[i];
      if (load) nCount = mStart[i];
      else if (rlw) nCount = 0;
      else if (step) nCount = exp ? 32'd0 : mCount[i] - 1;
      if (load) mDone[i] = 0; else if (exp) mDone[i] = 1;
      if (exp) mPend[i] = 1; else if (wa && d[5]) mPend[i] = 0;
      if (rlw) mStart[i] = d;
      if (wa) mIe[i] = d[0];
      if (wc) begin mRun[i] = d[0]; mSrc[i] = d[5:4]; end
      mCount[i] = nCount;
    end
  endtask

  task automatic doCycle(input logic wr, input logic [5:0] a, input logic [31:0] d,
                         input logic [3:0] t);
    @(negedge clk);
    busWr = wr; busAddr = a; busWdata = d; tickIn = t;
    @(posedge clk);
    modelStep(wr, a, d, t);
    @(negedge clk);
    busWr = 0; tickIn = 0;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readChk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    #1;
    check(busRdata, exp, tag);
  endtask

  task automatic checkAll();
    for (int i = 0; i < NT; i++) begin
      for (int r = 0; r < 4; r++) begin
        logic [5:0] a = {2'(i), 2'(r), 2'b00};
        string tag = (r == 0) ? "R2 ctrl" : (r == 1) ? "R7 start" : (r == 2) ? "R4 count" : "R8 ack";
        readChk(a, expWord(a), tag);
      end
    end
    check({28'b0, irq}, {28'b0, expIrq()}, "R8 irq");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 64; a += 4) readChk(6'(a), 32'd0, "R1 reset read");
    check({28'b0, irq}, 32'd0, "R1 reset irq");

    // R3 / R4 / R5 / R7 / R8 / R6 on timer 0, medium strobe
    doCycle(1, 6'h04, 32'd3, 4'b0000);
    doCycle(1, 6'h00, 32'h11, 4'b0000);
    readChk(6'h08, 32'd3, "R3 load on start");
    readChk(6'h00, 32'h11, "R2 ctrl fields");
    doCycle(0, 6'h00, 0, 4'b1101);
    readChk(6'h08, 32'd3, "R4 unselected strobes");
    doCycle(0, 6'h00, 0, 4'b0010);
    readChk(6'h08, 32'd2, "R4 decrement");
    doCycle(1, 6'h04, 32'd7, 4'b0000);
    readChk(6'h04, 32'd3, "R7 write while running ignored");
    doCycle(0, 6'h00, 0, 4'b0010);
    doCycle(0, 6'h00, 0, 4'b0010);
    readChk(6'h08, 32'd0, "R5 reached zero");
    readChk(6'h0C, 32'h20, "R5 pending set");
    check({31'b0, irq[0]}, 32'd0, "R8 irq masked");
    doCycle(0, 6'h00, 0, 4'b1111);
    readChk(6'h08, 32'd0, "R5 holds no restart");
    doCycle(1, 6'h0C, 32'h01, 4'b0000);
    check({31'b0, irq[0]}, 32'd1, "R8 irq raised");
    doCycle(1, 6'h0C, 32'h21, 4'b0000);
    check({31'b0, irq[0]}, 32'd0, "R8 clear drops irq");
    readChk(6'h0C, 32'h01, "R8 pending cleared");
    doCycle(1, 6'h00, 32'h10, 4'b0000);
    readChk(6'h08, 32'd0, "R6 stopped reads zero");

    // R10: zero start value, CPU-rate strobe on timer 1
    doCycle(1, 6'h14, 32'd0, 4'b0000);
    doCycle(1, 6'h10, 32'h21, 4'b0000);
    doCycle(0, 6'h00, 0, 4'b0100);
    readChk(6'h1C, 32'h20, "R10 zero start expires");

    // R11: expiry and clear in the same cycle, timer 2 slow strobe
    doCycle(1, 6'h24, 32'd1, 4'b0000);
    doCycle(1, 6'h20, 32'h01, 4'b0000);
    doCycle(1, 6'h2C, 32'h21, 4'b0001);
    readChk(6'h2C, 32'h21, "R11 set wins over clear");
    check({31'b0, irq[2]}, 32'd1, "R11 irq");

    // R9: timer 3 decode and isolation
    doCycle(1, 6'h34, 32'h0000_BEEF, 4'b0000);
    readChk(6'h34, 32'h0000_BEEF, "R9 own slot");
    readChk(6'h04, 32'd3, "R9 other timer untouched");
    readChk(6'h24, 32'd1, "R9 other timer untouched");
    checkAll();

    // random mix against the model
    for (int n = 0; n < 400; n++) begin
      int op = $urandom % 4;
      logic [5:0] a = {2'($urandom % 4), 4'b0000};
      logic [31:0] d = 0;
      logic [3:0] t = ($urandom % 2) ? 4'($urandom) : 4'b0000;
      logic wr = 1;
      case (op)
        0: begin a[3:2] = 2'd0; d = {26'b0, 2'($urandom), 3'b0, 1'($urandom)}; end
        1: begin a[3:2] = 2'd1; d = ($urandom % 8 == 0) ? 32'd0 : 32'(1 + $urandom % 12); end
        2: begin a[3:2] = 2'd3; d = {26'b0, 1'($urandom), 4'b0, 1'($urandom)}; end
        default: begin wr = 0; t = 4'($urandom); end
      endcase
      doCycle(wr, a, d, t);
      check({28'b0, irq}, {28'b0, expIrq()}, "R8 irq random");
      if (n % 8 == 7) checkAll();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule